// File: doc/BRIEF.md
# Asynchronous SRAM interface controller

This block sits between on-chip logic and an external 64K x 16 asynchronous static RAM. Single-word read and write requests come in over a ready/valid handshake. The block turns each request into a timed sequence on the active-low chip enable, write enable, output enable and per-byte strobes. It also controls the 16-bit bidirectional data bus through separate output, output-enable and input signals. Reads return their data together with a one-cycle done pulse.

Every phase length is derived at elaboration time from the clock period parameter and a set of nanosecond minimums. Each minimum is divided by the period and rounded up, with a floor of one cycle. A read holds chip enable and output enable low for the whole access and captures the bus on its last cycle. A write holds write enable low for the whole phase. During the first part of that phase the bus stays undriven while the memory releases it, and write data is driven for the remainder. After every access there is exactly one cycle with all strobes high. Chip enable therefore toggles between any two operations, including a read followed by a write.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and after its release, chip enable, write enable, output enable and both byte strobes are high, the data-bus drive enable is low, done is low and ready is high.
- R2: Ready is high only in the idle state. A request is taken on a clock edge where valid and ready are both high, and its command, address, data and byte mask are captured there. A valid that is held high during a busy access has no effect on the pins.
- R3: A read holds chip enable and output enable low and write enable high for N_RD cycles, the largest of ceil(150 ns / T), ceil(80 ns / T) and 1. Here T is the clock period. At T = 4 ns, N_RD is 38.
- R4: Read data is sampled at the end of the last read cycle and presented on rd_data_o in the done cycle. Byte lanes whose mask bit is 0 read as zero.
- R5: A write holds chip enable and write enable low and output enable high for N_WR cycles. N_WR is the largest of ceil(150/T), ceil(80/T), ceil(70/T) and N_TURN + ceil(40/T). At T = 4 ns, N_WR is 38.
- R6: During a write, the drive enable is low for the first N_TURN = ceil(40/T) cycles (10 at 4 ns). It is then high, with the write data on the bus, until write enable rises.
- R7: Mask bit 0 controls strobe bit 0, which gates data bits 7:0. Mask bit 1 controls strobe bit 1, which gates bits 15:8. A strobe is low for the whole access phase only when its mask bit is 1.
- R8: After each access, one cycle follows with every strobe high, the drive enable low and done high. The controller then returns to idle.
- R9: The address is held stable for the whole of a read or write phase. It changes only on the edge that starts an access.
- R10: A write changes only the byte lanes whose mask bit is 1. A write with mask 00 leaves the memory unchanged.
- R11: The data bus is never driven while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 16 | Read data, valid with done after a read |
| sram_addr_o | output | 16 | Memory address |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_bs_no | output | 2 | Byte strobes, active low, bit 0 lower lane |
| sram_dq_o | output | 16 | Data bus out value |
| sram_dq_oe_o | output | 1 | Data bus drive enable |
| sram_dq_i | input | 16 | Data bus in value |

## Verification
The bench builds the controller with its defaults: a 4 ns clock and the nanosecond minimums listed above. This gives 38-cycle read and write phases and a 10-cycle turnaround. At that period the address-to-end-of-write term sets the write length, not the turnaround-plus-setup term, and no phase falls to the one-cycle floor. The cases reached are lane-partial writes read back through either or both lanes, a mask-00 write, the address extremes, a valid held through a busy access, and reads and writes back to back.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_GAP
  } phase_e;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_RD   = 38,
  parameter int unsigned N_WR   = 38,
  parameter int unsigned N_TURN = 10,
  parameter int unsigned N_DW   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic req_write_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic act_next_o,
  output logic capture_o,
  output logic done_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);

  localparam int unsigned NMAX  = umax(N_RD, N_WR);
  localparam int unsigned CNT_W = $clog2(NMAX + 1);
  localparam int unsigned N_DRV = N_WR - N_TURN;
  localparam int unsigned RUN_W = CNT_W + 1;

  phase_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic last_c;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept_o    = req_valid_i && req_ready_o;
  assign last_c      = (cnt_q == '0);
  assign capture_o   = (st_q == ST_READ) && last_c;
  assign act_next_o  = (st_d == ST_READ) || (st_d == ST_WRITE);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) begin
        st_d  = req_write_i ? ST_WRITE : ST_READ;
        cnt_d = req_write_i ? CNT_W'(N_WR - 1) : CNT_W'(N_RD - 1);
      end
      ST_READ, ST_WRITE: begin
        if (last_c) st_d = ST_GAP;
        else        cnt_d = cnt_q - 1'b1;
      end
      ST_GAP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // pins decoded from next state so they leave a flop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      ce_no   <= 1'b1;
      we_no   <= 1'b1;
      oe_no   <= 1'b1;
      dq_oe_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ce_no   <= !act_next_o;
      we_no   <= (st_d != ST_WRITE);
      oe_no   <= (st_d != ST_READ);
      dq_oe_o <= (st_d == ST_WRITE) && (cnt_d < CNT_W'(N_DRV));
      done_o  <= ((st_q == ST_READ) || (st_q == ST_WRITE)) && last_c;
    end
  end

  // run-length counters for pulse-width checks
  logic [RUN_W-1:0] we_run_q, oe_run_q, drv_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run_q  <= '0;
      oe_run_q  <= '0;
      drv_run_q <= '0;
    end else begin
      we_run_q  <= we_no    ? '0 : ((&we_run_q)  ? we_run_q  : we_run_q + 1'b1);
      oe_run_q  <= oe_no    ? '0 : ((&oe_run_q)  ? oe_run_q  : oe_run_q + 1'b1);
      drv_run_q <= !dq_oe_o ? '0 : ((&drv_run_q) ? drv_run_q : drv_run_q + 1'b1);
    end
  end

  p_read_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_no) |-> oe_run_q >= RUN_W'(N_RD));

  p_write_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> we_run_q >= RUN_W'(N_WR));

  p_we_oe_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> oe_no);

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (!we_no && we_run_q >= RUN_W'(N_TURN)));

  p_data_setup_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> drv_run_q >= RUN_W'(N_DW));

  p_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ce_no && we_no && oe_no && !dq_oe_o));

  p_no_conflict_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_no);

endmodule

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       act_next_i,
  input  logic       capture_i,
  input  logic       be_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] dq_i,
  output logic       bs_no,
  output logic [7:0] dq_o,
  output logic [7:0] rdata_o
);

  logic mask_q, mask_d;

  assign mask_d = accept_i ? be_i : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= 1'b0;
      bs_no   <= 1'b1;
      dq_o    <= '0;
      rdata_o <= '0;
    end else begin
      mask_q <= mask_d;
      bs_no  <= !(act_next_i && mask_d);
      if (accept_i)  dq_o    <= wdata_i;
      if (capture_i) rdata_o <= mask_q ? dq_i : 8'h00;
    end
  end

  p_strobe_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bs_no && !$past(bs_no)) |-> $stable(dq_o));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned T_CYCLE_NS    = 150,
  parameter int unsigned T_ADDR_ACC_NS = 150,
  parameter int unsigned T_OE_ACC_NS   = 80,
  parameter int unsigned T_WE_PULSE_NS = 80,
  parameter int unsigned T_ADDR_END_NS = 150,
  parameter int unsigned T_BYTE_END_NS = 70,
  parameter int unsigned T_DSETUP_NS   = 40,
  parameter int unsigned T_RELEASE_NS  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_we_no,
  output logic              sram_oe_no,
  output logic [DATA_W/8-1:0] sram_bs_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned C_CYC  = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_AA   = ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned C_OE   = ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned C_WP   = ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned C_AW   = ns_to_cyc(T_ADDR_END_NS, CLK_PERIOD_NS);
  localparam int unsigned C_BW   = ns_to_cyc(T_BYTE_END_NS, CLK_PERIOD_NS);
  localparam int unsigned C_DW   = ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned N_TURN = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned N_RD   = umax(C_CYC, umax(C_AA, C_OE));
  localparam int unsigned N_WR   = umax(umax(C_CYC, C_AW), umax(umax(C_WP, C_BW), N_TURN + C_DW));

  logic accept, act_next, capture;

  sram_ctrl_seq #(
    .N_RD  (N_RD),
    .N_WR  (N_WR),
    .N_TURN(N_TURN),
    .N_DW  (C_DW)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_write_i(req_write_i),
    .req_ready_o(req_ready_o),
    .accept_o   (accept),
    .act_next_o (act_next),
    .capture_o  (capture),
    .done_o     (done_o),
    .ce_no      (sram_ce_no),
    .we_no      (sram_we_no),
    .oe_no      (sram_oe_no),
    .dq_oe_o    (sram_dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sram_addr_o <= '0;
    else if (accept) sram_addr_o <= req_addr_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_ctrl_lane u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .accept_i  (accept),
      .act_next_i(act_next),
      .capture_i (capture),
      .be_i      (req_be_i[l]),
      .wdata_i   (req_wdata_i[8*l +: 8]),
      .dq_i      (sram_dq_i[8*l +: 8]),
      .bs_no     (sram_bs_no[l]),
      .dq_o      (sram_dq_o[8*l +: 8]),
      .rdata_o   (rd_data_o[8*l +: 8])
    );
  end

  p_addr_we_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_we_no && $past(!sram_we_no)) |-> $stable(sram_addr_o));

  p_addr_oe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_oe_no && $past(!sram_oe_no)) |-> $stable(sram_addr_o));

  p_ready_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sram_ce_no && !done_o));

endmodule

// File: tb/sram_ctrl_bench.sv
`timescale 1ns/1ps
module sram_ctrl_bench;

  localparam int PER    = 4;
  localparam int N_RD   = (150 + PER - 1) / PER;
  localparam int N_TURN = (40 + PER - 1) / PER;
  localparam int N_WR   = (150 + PER - 1) / PER;
  localparam int WD     = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready, done, ce_n, we_n, oe_n, dq_oe;
  logic [15:0] rdata, s_addr, dq_o;
  logic [15:0] dq_i = 16'hA5A5;
  logic [1:0]  bs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [15:0] ram [int];
  logic [15:0] ref_mem [int];

  always #(PER/2) clk = ~clk;

  sram_ctrl u_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_ready_o(ready), .req_write_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_be_i(be),
    .done_o(done), .rd_data_o(rdata),
    .sram_addr_o(s_addr), .sram_ce_no(ce_n), .sram_we_no(we_n),
    .sram_oe_no(oe_n), .sram_bs_no(bs_n), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i)
  );

  // behavioural memory driven only by the pins
  always @(posedge clk) begin
    if (rst_n && !ce_n && !we_n && dq_oe) begin
      logic [15:0] w;
      w = ram.exists(int'(s_addr)) ? ram[int'(s_addr)] : 16'h0000;
      if (!bs_n[0]) w[7:0]  = dq_o[7:0];
      if (!bs_n[1]) w[15:8] = dq_o[15:8];
      ram[int'(s_addr)] = w;
    end
  end

  always @(negedge clk) begin
    logic [15:0] v;
    v = ram.exists(int'(s_addr)) ? ram[int'(s_addr)] : 16'h0000;
    if (!ce_n && !oe_n && we_n)
      dq_i <= {bs_n[1] ? 8'hA5 : v[15:8], bs_n[0] ? 8'hA5 : v[7:0]};
    else
      dq_i <= 16'hA5A5;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD) begin
      errors++;
      $display("FAIL watchdog act=%0d exp<%0d", cyc, WD);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // bus conflict watch, every cycle
  always @(negedge clk) if (rst_n) chk("R11 drive while oe low", {31'd0, dq_oe & ~oe_n}, 32'd0);

  task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input logic hold);
    logic [15:0] expd;
    int n;
    @(negedge clk);
    chk("R2 ready idle", {31'd0, ready}, 32'd1);
    chk("R1 ce idle", {31'd0, ce_n}, 32'd1);
    valid = 1'b1; wr = w; addr = a; wdata = d; be = m;
    n = w ? N_WR : N_RD;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (hold) begin addr = ~a; wdata = ~d; wr = ~w; end
        else valid = 1'b0;
      end
      chk("R2 busy not ready", {31'd0, ready}, 32'd0);
      chk("R9 address", {16'd0, s_addr}, {16'd0, a});
      chk("R7 strobes", {30'd0, bs_n}, {30'd0, ~m});
      chk("R3/R5 ce", {31'd0, ce_n}, 32'd0);
      chk("R8 done low", {31'd0, done}, 32'd0);
      if (w) begin
        chk("R5 we", {31'd0, we_n}, 32'd0);
        chk("R5 oe", {31'd0, oe_n}, 32'd1);
        chk("R6 drive", {31'd0, dq_oe}, {31'd0, (i >= N_TURN)});
        if (i >= N_TURN) chk("R6 data", {16'd0, dq_o}, {16'd0, d});
      end else begin
        chk("R3 we", {31'd0, we_n}, 32'd1);
        chk("R3 oe", {31'd0, oe_n}, 32'd0);
        chk("R3 no drive", {31'd0, dq_oe}, 32'd0);
      end
    end
    @(negedge clk);
    valid = 1'b0;
    chk("R8 gap ce", {31'd0, ce_n}, 32'd1);
    chk("R8 gap we/oe", {30'd0, we_n, oe_n}, 32'd3);
    chk("R8 gap strobes", {30'd0, bs_n}, 32'd3);
    chk("R8 gap drive", {31'd0, dq_oe}, 32'd0);
    chk("R8 done", {31'd0, done}, 32'd1);
    if (w) begin
      expd = ref_rd(a);
      if (m[0]) expd[7:0]  = d[7:0];
      if (m[1]) expd[15:8] = d[15:8];
      ref_mem[int'(a)] = expd;
    end else begin
      expd = ref_rd(a);
      expd = {m[1] ? expd[15:8] : 8'h00, m[0] ? expd[7:0] : 8'h00};
      chk("R4/R10 read data", {16'd0, rdata}, {16'd0, expd});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ce/we/oe", {29'd0, ce_n, we_n, oe_n}, 32'd7);
    chk("R1 reset strobes", {30'd0, bs_n}, 32'd3);
    chk("R1 reset drive/done", {30'd0, dq_oe, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset ready", {31'd0, ready}, 32'd1);
    chk("R1 after reset ce", {31'd0, ce_n}, 32'd1);

    access(1'b1, 16'h1234, 16'hBEEF, 2'b11, 1'b0);
    access(1'b0, 16'h1234, 16'h0000, 2'b11, 1'b0);
    access(1'b1, 16'h1234, 16'h0055, 2'b01, 1'b0);   // R10 lower lane only
    access(1'b0, 16'h1234, 16'h0000, 2'b11, 1'b0);
    access(1'b1, 16'h1234, 16'h7700, 2'b10, 1'b0);   // R10 upper lane only
    access(1'b0, 16'h1234, 16'h0000, 2'b01, 1'b0);   // R4 upper masked to zero
    access(1'b1, 16'h1234, 16'hFFFF, 2'b00, 1'b0);   // R10 mask 00 no effect
    access(1'b0, 16'h1234, 16'h0000, 2'b10, 1'b0);
    access(1'b0, 16'h1234, 16'h0000, 2'b11, 1'b0);
    access(1'b1, 16'h0000, 16'hC3C3, 2'b11, 1'b1);   // R2 valid held while busy
    access(1'b1, 16'hFFFF, 16'h3C5A, 2'b11, 1'b0);
    access(1'b0, 16'h0000, 16'h0000, 2'b11, 1'b1);
    access(1'b0, 16'hFFFF, 16'h0000, 2'b11, 1'b0);
    access(1'b0, 16'hEDCB, 16'h0000, 2'b11, 1'b0);   // R4 unwritten reads zero
    access(1'b1, 16'hEDCB, 16'h9182, 2'b01, 1'b0);   // read then write
    access(1'b0, 16'hEDCB, 16'h0000, 2'b11, 1'b0);
    access(1'b0, 16'hFFFF, 16'h0000, 2'b11, 1'b0);   // R9 no aliasing
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule